// File: doc/BRIEF.md
# Lockable GPIO Port with Dual Function Select

An eight-pin general-purpose I/O port controller behind a small register bus. Software programs direction, output value, internal resistor enable and a two-bit peripheral function code per pin. It also programs which edge of each pin raises an interrupt flag, and which flags reach the single interrupt line. The function code comes from two select registers. A third, write-only register inverts chosen bits of both select registers in one clock cycle, so a pin never passes through an unintended function code on its way between two settings.

A global lock holds every pad in its safe state: no drive, no pull, function code zero. The lock is set by reset. Register writes are accepted while it is set. Software writes the full configuration, clears the lock with a bus write, clears any stale flags and then enables interrupts. The lock cannot be set again except by reset.

Pin inputs pass through a two-flop synchroniser and a previous-value register. The synchronised levels can always be read, and edges on them set flags. Writes take effect at the clock edge that samples them. Reads are combinational on the address.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset every pad output (`pad_oe`, `pad_out`, `pad_pu`, `pad_pd`, `pad_fsel`) is zero and `irq` is 0. The lock register at address 10 reads 1 in bit 0. The stored registers read 0.
- R2: While locked, writes to OUT (1), DIR (2), PULL (3), SEL0 (4), SEL1 (5), EDGE (7), IEN (8) and FLAG (9) are stored and read back. The pads stay at the all-zero safe state.
- R3: Writing 0 to bit 0 of address 10 clears the lock, and the configured settings appear on the pads in the next cycle. Writing 1 there never sets the lock again.
- R4: When unlocked, `pad_oe` equals DIR and `pad_out` equals OUT AND DIR.
- R5: When unlocked, a pin with PULL=1 and DIR=0 gets a pull-up if its OUT bit is 1 and a pull-down if it is 0. Any other pin gets no pull, and the two pull outputs are never both 1.
- R6: When unlocked, `pad_fsel[2i+1:2i]` equals {SEL1[i], SEL0[i]}. The code 00 is plain GPIO.
- R7: Writing a mask to address 6 inverts the masked bits of both SEL0 and SEL1 in the same cycle and leaves unmasked bits unchanged. Address 6 reads 0.
- R8: Address 0 returns the pin levels two clock edges after they change, whatever the pin direction.
- R9: EDGE bit 0 makes a rising synchronised edge set the flag, and bit 1 makes a falling edge set it. The flag is set three clock edges after the pin changes, and the opposite edge sets nothing.
- R10: Changing an EDGE bit while the pin is steady does not set the flag.
- R11: Writing FLAG stores the written value (1 sets, 0 clears). An edge detected in the same cycle as a write of 0 still leaves that flag set.
- R12: `irq` is 1 exactly when some pin has both its FLAG and IEN bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_i | input | 8 | Pad input levels |
| pad_oe | output | 8 | Output enable per pin |
| pad_out | output | 8 | Output value per pin |
| pad_pu | output | 8 | Pull-up enable per pin |
| pad_pd | output | 8 | Pull-down enable per pin |
| pad_fsel | output | 16 | Two-bit function code per pin |
| irq | output | 1 | Interrupt request |

## Verification
A software write to the flag register and a hardware-detected pin edge can fall in the same cycle. The bench provokes this by changing a pin and then timing a clearing write of FLAG so that the clock edge that captures the write is the one at which the synchroniser reports the edge. Bits that were set before the write must end up cleared, and the bit of the edging pin must survive. Every pin is also swept through both edge senses, and a complement-select sequence is checked against a model kept in the bench.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_IN   = 4'd0;
  localparam logic [ADDR_W-1:0] A_OUT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_DIR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PULL = 4'd3;
  localparam logic [ADDR_W-1:0] A_SEL0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_SEL1 = 4'd5;
  localparam logic [ADDR_W-1:0] A_SELX = 4'd6;
  localparam logic [ADDR_W-1:0] A_EDGE = 4'd7;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd8;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd9;
  localparam logic [ADDR_W-1:0] A_LOCK = 4'd10;

  // Per-pin drive bundle towards the pad
  typedef struct packed {
    logic       oe;
    logic       dout;
    logic       pu;
    logic       pd;
    logic [1:0] fsel;
  } pad_drive_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] edge_sel,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] hit_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic rise;
    logic fall;
    always_comb begin
      rise     = sync_q[i] & ~prev_q[i];
      fall     = ~sync_q[i] & prev_q[i];
      hit_o[i] = edge_sel[i] ? fall : rise;
    end
  end

  assign level_o = sync_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_lock_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  edge_hit,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic [WIDTH-1:0]  sel0_q,
  output logic [WIDTH-1:0]  sel1_q,
  output logic [WIDTH-1:0]  edge_q,
  output logic [WIDTH-1:0]  ien_q,
  output logic [WIDTH-1:0]  flag_q,
  output logic              lock_q
);

  logic [WIDTH-1:0] out_d, dir_d, pull_d, sel0_d, sel1_d, edge_d, ien_d, flag_d;
  logic             lock_d;

  // Next-state
  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    pull_d = pull_q;
    sel0_d = sel0_q;
    sel1_d = sel1_q;
    edge_d = edge_q;
    ien_d  = ien_q;
    flag_d = flag_q;
    lock_d = lock_q;
    if (wr_en) begin
      case (wr_addr)
        A_OUT:  out_d  = wr_data;
        A_DIR:  dir_d  = wr_data;
        A_PULL: pull_d = wr_data;
        A_SEL0: sel0_d = wr_data;
        A_SEL1: sel1_d = wr_data;
        A_SELX: begin
          sel0_d = sel0_q ^ wr_data;
          sel1_d = sel1_q ^ wr_data;
        end
        A_EDGE: edge_d = wr_data;
        A_IEN:  ien_d  = wr_data;
        A_FLAG: flag_d = wr_data;
        A_LOCK: lock_d = lock_q & wr_data[0];
        default: ;
      endcase
    end
    // a detected edge wins over a clearing write in the same cycle
    flag_d = flag_d | edge_hit;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      sel0_q <= '0;
      sel1_q <= '0;
      edge_q <= '0;
      ien_q  <= '0;
      flag_q <= '0;
      lock_q <= 1'b1;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      pull_q <= pull_d;
      sel0_q <= sel0_d;
      sel1_q <= sel1_d;
      edge_q <= edge_d;
      ien_q  <= ien_d;
      flag_q <= flag_d;
      lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/gpio_pad_gate.sv
module gpio_pad_gate
  import gpio_lock_pkg::*;
(
  input  logic       locked,
  input  logic       dir,
  input  logic       dout,
  input  logic       pull,
  input  logic       sel0,
  input  logic       sel1,
  output pad_drive_t drv
);

  always_comb begin
    if (locked) begin
      drv = '0;
    end else begin
      drv.oe   = dir;
      drv.dout = dir & dout;
      drv.pu   = pull & ~dir & dout;
      drv.pd   = pull & ~dir & ~dout;
      drv.fsel = {sel1, sel0};
    end
  end

endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
  import gpio_lock_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WIDTH-1:0]   bus_wdata,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   pin_i,
  output logic [WIDTH-1:0]   pad_oe,
  output logic [WIDTH-1:0]   pad_out,
  output logic [WIDTH-1:0]   pad_pu,
  output logic [WIDTH-1:0]   pad_pd,
  output logic [2*WIDTH-1:0] pad_fsel,
  output logic               irq
);

  logic             rst_q_n;
  logic [WIDTH-1:0] out_q, dir_q, pull_q, sel0_q, sel1_q, edge_q, ien_q, flag_q;
  logic             lock_q;
  logic [WIDTH-1:0] level, hit;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  gpio_edge #(.WIDTH(WIDTH)) u_edge (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .pin_i    (pin_i),
    .edge_sel (edge_q),
    .level_o  (level),
    .hit_o    (hit)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (bus_we),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .edge_hit (hit),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .pull_q   (pull_q),
    .sel0_q   (sel0_q),
    .sel1_q   (sel1_q),
    .edge_q   (edge_q),
    .ien_q    (ien_q),
    .flag_q   (flag_q),
    .lock_q   (lock_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    pad_drive_t drv;
    gpio_pad_gate u_gate (
      .locked (lock_q),
      .dir    (dir_q[i]),
      .dout   (out_q[i]),
      .pull   (pull_q[i]),
      .sel0   (sel0_q[i]),
      .sel1   (sel1_q[i]),
      .drv    (drv)
    );
    assign pad_oe[i]          = drv.oe;
    assign pad_out[i]         = drv.dout;
    assign pad_pu[i]          = drv.pu;
    assign pad_pd[i]          = drv.pd;
    assign pad_fsel[2*i +: 2] = drv.fsel;
  end

  assign irq = |(flag_q & ien_q);

  always_comb begin
    case (bus_addr)
      A_IN:    bus_rdata = level;
      A_OUT:   bus_rdata = out_q;
      A_DIR:   bus_rdata = dir_q;
      A_PULL:  bus_rdata = pull_q;
      A_SEL0:  bus_rdata = sel0_q;
      A_SEL1:  bus_rdata = sel1_q;
      A_EDGE:  bus_rdata = edge_q;
      A_IEN:   bus_rdata = ien_q;
      A_FLAG:  bus_rdata = flag_q;
      A_LOCK:  bus_rdata = {{(WIDTH-1){1'b0}}, lock_q};
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_lock_port_chk.sv
module gpio_lock_port_chk
  import gpio_lock_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [WIDTH-1:0]   bus_wdata,
  input logic               lock_q,
  input logic [WIDTH-1:0]   sel0_q,
  input logic [WIDTH-1:0]   sel1_q,
  input logic [WIDTH-1:0]   flag_q,
  input logic [WIDTH-1:0]   pad_oe,
  input logic [WIDTH-1:0]   pad_out,
  input logic [WIDTH-1:0]   pad_pu,
  input logic [WIDTH-1:0]   pad_pd,
  input logic [2*WIDTH-1:0] pad_fsel
);

  // R2
  locked_pads_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (pad_oe == '0 && pad_out == '0 && pad_pu == '0 &&
                pad_pd == '0 && pad_fsel == '0));

  // R3
  lock_never_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q);

  // R5
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) == '0) && ((pad_oe & (pad_pu | pad_pd)) == '0));

  // R7
  selx_both_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SELX) |=>
      (sel0_q == ($past(sel0_q) ^ $past(bus_wdata)) &&
       sel1_q == ($past(sel1_q) ^ $past(bus_wdata))));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

endmodule

bind gpio_lock_port gpio_lock_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .lock_q    (lock_q),
  .sel0_q    (sel0_q),
  .sel1_q    (sel1_q),
  .flag_q    (flag_q),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .pad_fsel  (pad_fsel)
);

// File: tb/gpio_lock_port_tb.sv
`timescale 1ns/1ps
module gpio_lock_port_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_i;
  logic [7:0]  pad_oe, pad_out, pad_pu, pad_pd;
  logic [15:0] pad_fsel;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  gpio_lock_port #(.WIDTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_fsel(pad_fsel), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] fsel_of(input logic [7:0] s0, input logic [7:0] s1);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) r[2*i +: 2] = {s1[i], s0[i]};
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, dir, outv, pl, s0, s1, m, ien;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #0.5;
    chk("R1 oe", pad_oe, 0); chk("R1 pu", pad_pu, 0); chk("R1 pd", pad_pd, 0);
    chk("R1 out", pad_out, 0); chk("R1 fsel", pad_fsel, 0); chk("R1 irq", irq, 0);
    rd(4'd10, d); chk("R1 lock", d, 1);
    for (int a = 1; a <= 9; a++) begin rd(a[3:0], d); chk("R1 regs", d, 0); end

    // R2 writes accepted while locked, pads safe
    for (int a = 1; a <= 9; a++) begin
      if (a == 6) continue;
      wr(a[3:0], 8'((a * 37 + 11) & 255));
      rd(a[3:0], d); chk("R2 readback", d, (a * 37 + 11) & 255);
      chk("R2 oe", pad_oe, 0); chk("R2 fsel", pad_fsel, 0);
      chk("R2 pulls", {pad_pu, pad_pd}, 0);
    end
    wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd7, 8'h00);

    // R3 unlock
    wr(4'd10, 8'h01); rd(4'd10, d); chk("R3 write1 keeps lock", d, 1);
    chk("R3 still safe", pad_oe, 0);
    wr(4'd10, 8'h00); rd(4'd10, d); chk("R3 cleared", d, 0);
    chk("R3 dir on pads", pad_oe, (2 * 37 + 11) & 255);
    wr(4'd10, 8'hFF); rd(4'd10, d); chk("R3 no relock", d, 0);

    // R4 R5 sweep
    for (int i = 0; i < 32; i++) begin
      dir = 8'(i * 29) ^ 8'h3C; outv = 8'(i * 53 + 7); pl = 8'(i * 71) ^ 8'hA5;
      wr(4'd2, dir); wr(4'd1, outv); wr(4'd3, pl);
      #0.5;
      chk("R4 oe", pad_oe, dir); chk("R4 out", pad_out, dir & outv);
      chk("R5 pu", pad_pu, pl & ~dir & outv); chk("R5 pd", pad_pd, pl & ~dir & ~outv);
    end

    // R6 codes
    for (int c = 0; c < 4; c++) begin
      s0 = c[0] ? 8'hFF : 8'h00; s1 = c[1] ? 8'hFF : 8'h00;
      wr(4'd4, s0); wr(4'd5, s1); #0.5;
      chk("R6 uniform code", pad_fsel, fsel_of(s0, s1));
    end
    s0 = 8'h5A; s1 = 8'h33; wr(4'd4, s0); wr(4'd5, s1); #0.5;
    chk("R6 mixed code", pad_fsel, fsel_of(s0, s1));

    // R7 complement sweep
    for (int k = 0; k < 16; k++) begin
      m = 8'(k * 23) ^ 8'h69;
      wr(4'd6, m); s0 ^= m; s1 ^= m;
      rd(4'd4, d); chk("R7 sel0", d, s0);
      rd(4'd5, d); chk("R7 sel1", d, s1);
      rd(4'd6, d); chk("R7 reads zero", d, 0);
      chk("R7 pads", pad_fsel, fsel_of(s0, s1));
    end
    wr(4'd6, 8'h00); rd(4'd4, d); chk("R7 zero mask", d, s0);

    // R8 input levels, mixed direction
    wr(4'd2, 8'hF0);
    for (int k = 0; k < 8; k++) begin
      m = 8'(k * 45) ^ 8'h33;
      rd(4'd0, outv);
      @(negedge clk); pin_i = m;
      @(negedge clk); rd(4'd0, d); chk("R8 one edge old", d, outv);
      @(negedge clk); rd(4'd0, d); chk("R8 two edges", d, m);
    end

    // R9 every pin, both senses
    wr(4'd2, 8'h00);
    @(negedge clk); pin_i = 8'h00; repeat (4) @(negedge clk);
    for (int sense = 0; sense < 2; sense++) begin
      wr(4'd7, sense ? 8'hFF : 8'h00);
      wr(4'd9, 8'h00);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); pin_i[i] = 1'b1;
        repeat (2) @(negedge clk); rd(4'd9, d); chk("R9 not yet", d, 0);
        @(negedge clk); rd(4'd9, d); chk("R9 rise", d, sense ? 0 : (1 << i));
        wr(4'd9, 8'h00);
        @(negedge clk); pin_i[i] = 1'b0;
        repeat (3) @(negedge clk); rd(4'd9, d); chk("R9 fall", d, sense ? (1 << i) : 0);
        wr(4'd9, 8'h00);
      end
    end

    // R10 edge select change with steady pins
    @(negedge clk); pin_i = 8'h0F; repeat (4) @(negedge clk);
    wr(4'd9, 8'h00);
    wr(4'd7, 8'hFF); wr(4'd7, 8'h00); wr(4'd7, 8'hAA); repeat (3) @(negedge clk);
    rd(4'd9, d); chk("R10 no flag", d, 0);

    // R11 write semantics and same-cycle edge
    wr(4'd9, 8'hA5); rd(4'd9, d); chk("R11 set", d, 8'hA5);
    wr(4'd9, 8'h00); rd(4'd9, d); chk("R11 clear", d, 0);
    wr(4'd7, 8'h00); wr(4'd9, 8'hF0);
    @(negedge clk); pin_i[5] = 1'b1;
    @(negedge clk);
    wr(4'd9, 8'h00);
    rd(4'd9, d); chk("R11 edge wins same cycle", d, 8'h20);
    wr(4'd9, 8'h00);

    // R12 irq
    wr(4'd9, 8'h3C);
    for (int k = 0; k < 16; k++) begin
      ien = 8'(k * 17);
      wr(4'd8, ien); #0.5;
      chk("R12 irq", irq, (|(8'h3C & ien)) ? 1 : 0);
    end
    wr(4'd8, 8'hFF); wr(4'd9, 8'h00); #0.5; chk("R12 no flags", irq, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule